// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block applies one of seven bit-movement operations to an 8-bit or 16-bit operand: plain rotate in either direction, rotate in either direction with the carry flag as an extra bit in the loop, shift left, arithmetic shift right and logical shift right. It moves the working value by one bit position per clock cycle. The number of positions is either a fixed 1 or the value of an 8-bit count input. A carry output always holds the last bit moved out. An overflow output follows a single-step rule.

A caller places the operand, the operation code, the width select, the count source, the count and the incoming carry and overflow flags on the inputs, and pulses `start` while `busy` is low. The unit raises `busy` until the work is finished, then pulses `done` for one cycle. From that pulse onward, `result`, `cf_out` and `of_out` hold the outcome until the next start. Operand fetch and instruction decode stay with the caller.

Top module: `shrot_unit`

## Requirements
- R1: After reset, `result` is 0, `cf_out` is 0, `of_out` is 0, `done` is 0 and `busy` is 0.
- R2: With `cnt_src`=0 the count is exactly 1. With `cnt_src`=1 the count is the unsigned value of `cnt_reg` (0 to 255), with no masking.
- R3: A start accepted at clock edge E with count N raises `busy` from E. It pulses `done` high for exactly one cycle after edge E+N+1, and `busy` is low from that edge. The outputs stay stable after the pulse until the next start.
- R4: A count of zero returns the operand (restricted to the selected width) and leaves both flags at their incoming values.
- R5: `op_sel`=0 rotates left, with the MSB entering the LSB. `op_sel`=1 rotates right, with the LSB entering the MSB. In both cases the carry receives the last bit rotated.
- R6: `op_sel`=2 rotates left and `op_sel`=3 rotates right through the carry, as a 9-bit loop (byte) or a 17-bit loop (word). The carry enters the vacated end, and the bit that leaves becomes the new carry.
- R7: `op_sel`=4 shifts left with zeros entering the LSB. The carry receives the last bit shifted out of the MSB.
- R8: `op_sel`=5 shifts right and copies the sign bit into the MSB on every step. The carry receives the last bit shifted out of the LSB.
- R9: `op_sel`=6 shifts right with zeros entering the MSB. The carry receives the last bit shifted out of the LSB.
- R10: With `wide`=0, only operand bits 7..0 take part, bit 7 is the MSB, operand bits 15..8 are ignored, and `result` bits 15..8 are 0. With `wide`=1, bits 15..0 take part.
- R11: For a count of exactly 1 with `op_sel` 0 to 6, `of_out` is set as follows. For left operations (0, 2, 4) it is the result MSB XOR the final carry. For right operations (1, 3, 5, 6) it is the result MSB XOR the next-lower result bit.
- R12: For any count other than 1, `of_out` equals `of_in`.
- R13: `op_sel`=7 leaves the operand, the carry and the overflow unchanged, and still takes the normal number of cycles.
- R14: A `start` pulse while `busy` is high is ignored. The running operation completes with its original inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new operation; taken only while idle |
| op_sel | input | 3 | Operation code (0..7) |
| wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| cnt_src | input | 1 | 0 = count of one, 1 = count from `cnt_reg` |
| cnt_reg | input | 8 | Count value used when `cnt_src` is 1 |
| operand | input | 16 | Value to shift or rotate |
| cf_in | input | 1 | Incoming carry flag |
| of_in | input | 1 | Incoming overflow flag |
| result | output | 16 | Shifted or rotated value |
| cf_out | output | 1 | Carry flag after the operation |
| of_out | output | 1 | Overflow flag after the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- Count zero: a design that steps once anyway returns a moved value.
- Count of one: a design that tests the wrong bit pair returns a wrong overflow.
- Longer counts: a design that updates overflow on them returns a value other than `of_in`.
- Byte mode with dirty upper operand bits: a design that does not restrict the width lets those bits leak into `result` or into the carry taken from bit 7.
- Rotate through carry: a design that drops the carry from the loop returns values off by one position every 9 or 17 steps.
- Latency: every vector checks the cycle on which `done` appears.
- Start while busy: a start pulse with a different operand is raised in the middle of a run. A design that accepts it returns the wrong result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_ROL = 3'd0,
      OP_ROR = 3'd1,
      OP_RCL = 3'd2,
      OP_RCR = 3'd3,
      OP_SHL = 3'd4,
      OP_SAR = 3'd5,
      OP_SHR = 3'd6,
      OP_NOP = 3'd7
   } rot_op_e;

   function automatic logic op_is_left(rot_op_e op);
      return (op == OP_ROL) || (op == OP_RCL) || (op == OP_SHL);
   endfunction

endpackage

// File: rtl/shrot_bitstep.sv
module shrot_bitstep
   import shrot_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic              wide_i,
   input  rot_op_e           op_i,
   input  logic              cf_i,
   output logic [DATA_W-1:0] val_o,
   output logic              cf_o
);
   localparam int HALF = DATA_W / 2;

   logic              top_bit;
   logic              fill;
   logic [DATA_W-1:0] up_v;
   logic [DATA_W-1:0] dn_v;

   assign top_bit = wide_i ? val_i[DATA_W-1] : val_i[HALF-1];

   always_comb begin
      fill = 1'b0;
      cf_o = cf_i;
      case (op_i)
         OP_ROL:  begin fill = top_bit;  cf_o = top_bit;  end
         OP_RCL:  begin fill = cf_i;     cf_o = top_bit;  end
         OP_SHL:  begin fill = 1'b0;     cf_o = top_bit;  end
         OP_ROR:  begin fill = val_i[0]; cf_o = val_i[0]; end
         OP_RCR:  begin fill = cf_i;     cf_o = val_i[0]; end
         OP_SAR:  begin fill = top_bit;  cf_o = val_i[0]; end
         OP_SHR:  begin fill = 1'b0;     cf_o = val_i[0]; end
         default: begin fill = 1'b0;     cf_o = cf_i;     end
      endcase
   end

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_lane
         if (gi == 0) begin : g_low
            assign up_v[gi] = fill;
         end else begin : g_mid_up
            assign up_v[gi] = val_i[gi-1];
         end
         if (gi == DATA_W-1) begin : g_high
            assign dn_v[gi] = 1'b0;
         end else begin : g_mid_dn
            assign dn_v[gi] = val_i[gi+1];
         end
      end
   endgenerate

   always_comb begin
      if (op_i == OP_NOP) begin
         val_o = val_i;
      end else if (op_is_left(op_i)) begin
         val_o = up_v;
      end else begin
         val_o = dn_v;
         if (wide_i) val_o[DATA_W-1] = fill;
         else        val_o[HALF-1]   = fill;
      end
      if (!wide_i) val_o[DATA_W-1:HALF] = '0;
   end

endmodule

// File: rtl/shrot_ovf.sv
module shrot_ovf
   import shrot_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic              wide_i,
   input  rot_op_e           op_i,
   input  logic              cf_i,
   input  logic              of_i,
   input  logic              single_i,
   output logic              of_o
);
   localparam int HALF = DATA_W / 2;

   logic hi_bit;
   logic next_bit;

   assign hi_bit   = wide_i ? val_i[DATA_W-1] : val_i[HALF-1];
   assign next_bit = wide_i ? val_i[DATA_W-2] : val_i[HALF-2];

   always_comb begin
      if (!single_i || op_i == OP_NOP) of_o = of_i;
      else if (op_is_left(op_i))       of_o = hi_bit ^ cf_i;
      else                             of_o = hi_bit ^ next_bit;
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op_sel,
   input  logic              wide,
   input  logic              cnt_src,
   input  logic [CNT_W-1:0]  cnt_reg,
   input  logic [DATA_W-1:0] operand,
   input  logic              cf_in,
   input  logic              of_in,
   output logic [DATA_W-1:0] result,
   output logic              cf_out,
   output logic              of_out,
   output logic              busy,
   output logic              done
);
   localparam int HALF = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("shrot_unit: DATA_W must be even and at least 4");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("shrot_unit: CNT_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] val_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              cf_q, of_q, wide_q, one_q, busy_q, done_q;
   rot_op_e           op_q;

   logic [CNT_W-1:0]  eff_cnt;
   logic [DATA_W-1:0] step_val;
   logic              step_cf;
   logic              fin_of;
   logic [DATA_W-1:0] load_val;

   assign eff_cnt  = cnt_src ? cnt_reg : CNT_W'(1);
   assign load_val = wide ? operand : {{(DATA_W-HALF){1'b0}}, operand[HALF-1:0]};

   shrot_bitstep #(.DATA_W(DATA_W)) u_step (
      .val_i  (val_q),
      .wide_i (wide_q),
      .op_i   (op_q),
      .cf_i   (cf_q),
      .val_o  (step_val),
      .cf_o   (step_cf)
   );

   shrot_ovf #(.DATA_W(DATA_W)) u_ovf (
      .val_i    (val_q),
      .wide_i   (wide_q),
      .op_i     (op_q),
      .cf_i     (cf_q),
      .of_i     (of_q),
      .single_i (one_q),
      .of_o     (fin_of)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q  <= '0;
         cnt_q  <= '0;
         cf_q   <= 1'b0;
         of_q   <= 1'b0;
         wide_q <= 1'b0;
         one_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         op_q   <= OP_NOP;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               val_q  <= load_val;
               cf_q   <= cf_in;
               of_q   <= of_in;
               cnt_q  <= eff_cnt;
               one_q  <= (eff_cnt == CNT_W'(1));
               op_q   <= rot_op_e'(op_sel);
               wide_q <= wide;
               busy_q <= 1'b1;
            end
         end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            of_q   <= fin_of;
         end else begin
            val_q <= step_val;
            cf_q  <= step_cf;
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign result = val_q;
   assign cf_out = cf_q;
   assign of_out = of_q;
   assign busy   = busy_q;
   assign done   = done_q;

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q && eff_cnt == '0) |=> ##1 (done && !busy));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

   // R10
   byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wide_q) |-> (result[DATA_W-1:HALF] == '0));

   // R8
   sar_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0 && op_q == OP_SAR && wide_q)
         |=> (val_q[DATA_W-1] == $past(val_q[DATA_W-1])));

endmodule

// File: tb/shrot_unit_tb.sv
`timescale 1ns/1ps
module shrot_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_sel = '0;
   logic        wide = 1'b0;
   logic        cnt_src = 1'b0;
   logic [7:0]  cnt_reg = '0;
   logic [15:0] operand = '0;
   logic        cf_in = 1'b0;
   logic        of_in = 1'b0;
   logic [15:0] result;
   logic        cf_out, of_out, busy, done;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   shrot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .wide(wide),
      .cnt_src(cnt_src), .cnt_reg(cnt_reg), .operand(operand), .cf_in(cf_in),
      .of_in(of_in), .result(result), .cf_out(cf_out), .of_out(of_out),
      .busy(busy), .done(done)
   );

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(int op);
      case (op)
         0, 1: return "R5";
         2, 3: return "R6";
         4:    return "R7";
         5:    return "R8";
         6:    return "R9";
         default: return "R13";
      endcase
   endfunction

   // independent model of the requirements
   task automatic model(input int op, input bit wd, input int n, input int opd,
                        input bit cf, input bit of,
                        output int res, output bit cfo, output bit ofo);
      int w = wd ? 16 : 8;
      int mask = (1 << w) - 1;
      int v = opd & mask;
      bit c = cf;
      for (int k = 0; k < n; k++) begin
         bit hi = bit'((v >> (w-1)) & 1);
         bit lo = bit'(v & 1);
         case (op)
            0: begin c = hi; v = ((v << 1) | int'(hi)) & mask; end
            1: begin c = lo; v = (v >> 1) | (int'(lo) << (w-1)); end
            2: begin v = ((v << 1) | int'(c)) & mask; c = hi; end
            3: begin v = (v >> 1) | (int'(c) << (w-1)); c = lo; end
            4: begin c = hi; v = (v << 1) & mask; end
            5: begin c = lo; v = (v >> 1) | (int'(hi) << (w-1)); end
            6: begin c = lo; v = v >> 1; end
            default: ;
         endcase
      end
      res = v;
      cfo = c;
      ofo = of;
      if (n == 1 && op <= 6) begin
         bit t  = bit'((v >> (w-1)) & 1);
         bit t2 = bit'((v >> (w-2)) & 1);
         if (op == 0 || op == 2 || op == 4) ofo = t ^ c;
         else                               ofo = t ^ t2;
      end
   endtask

   task automatic run_vec(input int op, input bit wd, input bit src, input int creg,
                          input int opd, input bit cf, input bit of, input bit inject);
      int n = src ? creg : 1;
      int er; bit ec, eo;
      int cyc = 0;
      bit got = 0;
      string rq = req_of(op);
      model(op, wd, n, opd, cf, of, er, ec, eo);
      @(negedge clk);
      op_sel = 3'(op); wide = wd; cnt_src = src; cnt_reg = 8'(creg);
      operand = 16'(opd); cf_in = cf; of_in = of; start = 1'b1;
      while (!got && cyc < 600) begin
         @(negedge clk);
         cyc++;
         if (inject && cyc == 1) begin
            operand = ~16'(opd); op_sel = 3'((op + 3) % 7); cf_in = ~cf;
            cnt_src = 1'b0; start = 1'b1;
            check("R14", "busy during run", int'(busy), 1);
         end else begin
            start = 1'b0;
         end
         if (done) got = 1;
      end
      start = 1'b0;
      check("R3", "done latency", cyc, n + 2);
      check("R3", "busy low at done", int'(busy), 0);
      check(inject ? "R14" : (n == 0 ? "R4" : rq), "result", int'(result), er);
      check(wd ? rq : "R10", "carry", int'(cf_out), int'(ec));
      check(n == 1 ? "R11" : "R12", "overflow", int'(of_out), int'(eo));
      @(negedge clk);
      check("R3", "done single pulse", int'(done), 0);
      check("R3", "result held", int'(result), er);
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "result", int'(result), 0);
      check("R1", "cf", int'(cf_out), 0);
      check("R1", "of", int'(of_out), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "busy", int'(busy), 0);

      // directed corners
      run_vec(0, 1, 0, 99, 16'h8001, 0, 1, 0);   // R2 fixed one, R5, R11
      run_vec(1, 0, 0, 0,  16'hFF01, 0, 0, 0);   // R5, R10 upper ignored
      run_vec(2, 0, 1, 9,  16'h00A5, 1, 0, 0);   // R6 full 9-bit loop
      run_vec(3, 1, 1, 17, 16'h1234, 1, 1, 0);   // R6 full 17-bit loop
      run_vec(4, 1, 1, 0,  16'hBEEF, 1, 1, 0);   // R4 zero count
      run_vec(5, 1, 1, 5,  16'h8000, 0, 1, 0);   // R8, R12
      run_vec(5, 1, 0, 0,  16'hC000, 0, 1, 0);   // R11 sar one step
      run_vec(6, 0, 0, 0,  16'h0080, 0, 0, 0);   // R9, R11
      run_vec(6, 1, 1, 20, 16'hFFFF, 0, 0, 0);   // R9 long count
      run_vec(7, 1, 1, 4,  16'h5A5A, 1, 1, 0);   // R13
      run_vec(4, 0, 1, 255, 16'hAB81, 0, 1, 0);  // R2 full count
      run_vec(0, 1, 1, 6,  16'h0F0F, 0, 0, 1);   // R14 start while busy
      run_vec(2, 0, 1, 1,  16'h3340, 1, 0, 0);   // R11 rcl one step

      // constrained random
      for (int i = 0; i < 300; i++) begin
         int op   = int'($urandom_range(0, 7));
         bit wd   = bit'($urandom_range(0, 1));
         bit src  = ($urandom_range(0, 3) != 0);
         int creg = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 60))
                                                : int'($urandom_range(0, 20));
         bit inj  = (src && creg >= 2 && $urandom_range(0, 9) == 0);
         run_vec(op, wd, src, creg, int'($urandom_range(0, 16'hFFFF)),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), inj);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule